// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Collector

This block gathers a set of external interrupt lines into one request line for a processor. Each line passes through a synchroniser. Software then picks how the line is detected: on a rising edge, which is caught and held, or by level, which simply follows the synchronised input. Software can also mask the line by itself. A priority encoder reports the lowest-numbered source that is pending and not masked. The request output is raised whenever such a source exists.

The processor reaches the block through a small synchronous register port. It has separate read and write strobes and a 3-bit address. Read data is registered and appears on the clock edge that follows the read strobe. Reading the dedicated clear register returns the edge captures that were held and drops all of them in that same cycle. Level sources do not take part in this clear. A rising edge that is detected in the same cycle as the clear read is kept. The port has no data stream, so it has no valid/ready handshake: a strobe acts in the cycle it is seen.

Register map (3-bit address, 8-bit data, bit n belongs to source n):

| Address | Access | Meaning |
|---|---|---|
| 0 | read/write | mode: 1 = rising edge, 0 = level |
| 1 | read/write | mask: 1 = blocked |
| 2 | read only | pending bits |
| 3 | read only | bit 7 = valid, bits 2:0 = winning index |
| 4 | read clears | held edge captures (cleared by the read) |
| 5 to 7 | — | read as zero |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mode, mask and pending values are all zero, irq_out is low, rd_data is zero, and every register reads zero.
- R2: A source in level mode (mode bit 0) shows as pending exactly while its input, delayed by the SYNC_STAGES synchroniser flops, is high. It is never latched.
- R3: A source in edge mode (mode bit 1) becomes pending one cycle after a rising edge appears at its synchroniser output. It stays pending after the input falls.
- R4: A mask bit of 1 keeps its source out of irq_out and out of the priority status. The pending register at address 2 still shows that source.
- R5: irq_out is high exactly when some pending source has a mask bit of 0. It changes in the cycle its pending or mask state changes.
- R6: Address 3 reads bit 7 = 1 and bits 2:0 = index of the lowest-numbered pending, unmasked source. Bit 0 has the highest priority. When no such source exists, the whole byte reads 0.
- R7: A read of address 4 returns the held edge captures and clears all of them in that cycle. Level-mode pending bits are not changed by this read.
- R8: A rising edge detected in the same cycle as a read of address 4 stays pending after the clear.
- R9: rd_data takes the addressed value on the clock edge at which rd_en is high, and holds it otherwise. Addresses 5 to 7 read 0. Writes to addresses 2 to 7 change nothing.
- R10: A source that is switched from edge to level mode drops its held edge capture. From the next cycle on, it follows the level rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt inputs, asynchronous |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Request to the processor |

## Verification
The bench builds the block with the default values: eight sources, 8-bit data and a two-stage synchroniser. With these, every source maps one-to-one onto a data bit, and the full priority ladder from index 0 to index 7 shows up at the port. The two-cycle input delay is short enough that a sweep of clear-read offsets lands a detected rising edge exactly on the clear cycle, so the same-cycle case is certain to occur. A long random stretch mixes edge and level sources, masks, and clear reads against the behavioural model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_MODE = 3'd0,
    REG_MASK = 3'd1,
    REG_PEND = 3'd2,
    REG_PRIO = 3'd3,
    REG_CLR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchroniser, one chain per source bit.
module irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
// Rising-edge capture with a bulk clear; a capture seen during the clear survives.
module irq_edge_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] edge_mode,
  input  logic             clr_all,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] held
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] held_d;

  assign rise = sync_in & ~prev_q;

  always_comb begin
    if (clr_all) held_d = rise & edge_mode;
    else         held_d = (held | rise) & edge_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held   <= '0;
    end else begin
      prev_q <= sync_in;
      held   <= held_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
// Lowest index wins.
module irq_prio_enc #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign valid = |req;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    irq_in,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  irq_out
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] mode_q, mask_q;
  logic [NUM_SRC-1:0] sync_v, rise_v, edge_held, pend_vis, active;
  logic               clr_hit, prio_valid;
  logic [IDX_W-1:0]   prio_idx;
  logic [DATA_W-1:0]  rd_next;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_v)
  );

  assign clr_hit = rd_en && (reg_sel_e'(addr) == REG_CLR);

  irq_edge_latch #(.WIDTH(NUM_SRC)) edge_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_v), .edge_mode(mode_q),
    .clr_all(clr_hit), .rise(rise_v), .held(edge_held)
  );

  assign pend_vis = (mode_q & edge_held) | (~mode_q & sync_v);
  assign active   = pend_vis & ~mask_q;

  irq_prio_enc #(.WIDTH(NUM_SRC)) prio_i (
    .req(active), .valid(prio_valid), .idx(prio_idx)
  );

  assign irq_out = |active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        REG_MODE: mode_q <= wr_data[NUM_SRC-1:0];
        REG_MASK: mask_q <= wr_data[NUM_SRC-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_sel_e'(addr))
      REG_MODE: rd_next[NUM_SRC-1:0] = mode_q;
      REG_MASK: rd_next[NUM_SRC-1:0] = mask_q;
      REG_PEND: rd_next[NUM_SRC-1:0] = pend_vis;
      REG_PRIO: begin
        rd_next[DATA_W-1]  = prio_valid;
        rd_next[IDX_W-1:0] = prio_valid ? prio_idx : '0;
      end
      REG_CLR:  rd_next[NUM_SRC-1:0] = edge_held & mode_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic               clr_hit,
  input logic               prio_valid,
  input logic [IDX_W-1:0]   prio_idx,
  input logic [NUM_SRC-1:0] mode_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend_vis,
  input logic [NUM_SRC-1:0] rise_v,
  input logic [NUM_SRC-1:0] edge_held
);
  // R5: request line agrees with the priority encoder's verdict
  assert_irq_vs_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == prio_valid);

  // R6 / R4: the winner is pending and not masked
  assert_winner_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prio_valid |-> (pend_vis[prio_idx] && !mask_q[prio_idx]));

  // R7 / R8: after a clear only same-cycle edges remain
  assert_clear_leaves_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((edge_held & ~$past(rise_v)) == '0));

  // R3: held captures persist without a clear while mode stays edge
  assert_edge_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((edge_held & $past(edge_held & mode_q)) == $past(edge_held & mode_q)));

  // R10: level-mode sources keep no capture
  assert_level_no_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_held & ~$past(mode_q)) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .clr_hit(clr_hit),
  .prio_valid(prio_valid), .prio_idx(prio_idx), .mode_q(mode_q),
  .mask_q(mask_q), .pend_vis(pend_vis), .rise_v(rise_v), .edge_held(edge_held)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 8;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_out;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [7:0] m_mode = '0, m_mask = '0, m_held = '0, m_rd = '0;
  logic [7:0] hist[$];
  logic       m_irq = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [7:0] m_pend(input logic [7:0] syn);
    return (m_mode & m_held) | (~m_mode & syn);
  endfunction

  function automatic logic [7:0] m_status(input logic [7:0] act);
    for (int i = 0; i < N; i++) if (act[i]) return 8'h80 | 8'(i);
    return 8'h00;
  endfunction

  task automatic model_edge();
    logic [7:0] syn, prv, rise, pend;
    syn  = hist[S-1];
    prv  = hist[S];
    rise = syn & ~prv;
    pend = m_pend(syn);
    if (rd_en) begin
      case (addr)
        3'd0: m_rd = m_mode;
        3'd1: m_rd = m_mask;
        3'd2: m_rd = pend;
        3'd3: m_rd = m_status(pend & ~m_mask);
        3'd4: m_rd = m_held & m_mode;
        default: m_rd = 8'h00;
      endcase
    end
    if (rd_en && addr == 3'd4) m_held = rise & m_mode;
    else                       m_held = (m_held | rise) & m_mode;
    if (wr_en && addr == 3'd0) m_mode = wr_data;
    if (wr_en && addr == 3'd1) m_mask = wr_data;
    hist.push_front(irq_in);
    void'(hist.pop_back());
    m_irq = |(m_pend(hist[S-1]) & ~m_mask);
  endtask

  task automatic compare(input string what);
    vectors++;
    if (irq_out !== m_irq) begin
      miscompares++;
      $display("FAIL %s %s irq_out actual=%0b expected=%0b", cur_req, what, irq_out, m_irq);
    end
    if (rd_data !== m_rd) begin
      miscompares++;
      $display("FAIL %s %s rd_data actual=%02h expected=%02h", cur_req, what, rd_data, m_rd);
    end
  endtask

  // one clock: inputs already set, update model at edge, compare after
  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare("cycle");
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a; step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d; step();
  endtask

  task automatic expect_rd(input logic [7:0] exp, input string what);
    vectors++;
    if (rd_data !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%02h expected=%02h", cur_req, what, rd_data, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i <= S; i++) hist.push_back(8'h00);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    compare("reset");
    for (int a = 0; a < 5; a++) begin rd(3'(a)); expect_rd(8'h00, "reset read"); end

    // R2: level follows input, not latched
    cur_req = "R2";
    irq_in = 8'h08; idle(3);
    rd(3'd2); expect_rd(8'h08, "level pending");
    irq_in = 8'h00; idle(3);
    rd(3'd2); expect_rd(8'h00, "level released");

    // R3: edge captured and held
    cur_req = "R3";
    wr(3'd0, 8'hFF);
    irq_in = 8'h20; idle(2); irq_in = 8'h00; idle(4);
    rd(3'd2); expect_rd(8'h20, "edge held");

    // R4 / R5: mask blocks output but pending stays visible
    cur_req = "R4";
    wr(3'd1, 8'h20);
    rd(3'd2); expect_rd(8'h20, "masked still pending");
    rd(3'd3); expect_rd(8'h00, "masked not in status");
    cur_req = "R5";
    vectors++;
    if (irq_out !== 1'b0) begin miscompares++; $display("FAIL R5 irq_out actual=%0b expected=0", irq_out); end
    wr(3'd1, 8'h00);
    vectors++;
    if (irq_out !== 1'b1) begin miscompares++; $display("FAIL R5 irq_out actual=%0b expected=1", irq_out); end

    // R6: priority among several sources
    cur_req = "R6";
    irq_in = 8'h54; idle(2); irq_in = 8'h00; idle(3);
    rd(3'd3); expect_rd(8'h82, "lowest index wins");
    wr(3'd1, 8'h04);
    rd(3'd3); expect_rd(8'h84, "next after mask");

    // R7: clear read with mixed modes
    cur_req = "R7";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h0F);           // bits 0-3 edge, 4-7 level; sets of edge bits >3 drop
    irq_in = 8'h03; idle(2); irq_in = 8'h80; idle(3);
    rd(3'd4); expect_rd(8'h07, "clear returns captures");
    rd(3'd2); expect_rd(8'h80, "level kept, edges cleared");

    // R8: sweep clear timing against a fresh rising edge
    cur_req = "R8";
    irq_in = 8'h00; idle(4);
    for (int k = 0; k < 5; k++) begin
      irq_in = 8'h01;
      for (int j = 0; j < k; j++) step();
      rd(3'd4);
      idle(1);
      rd(3'd2);
      irq_in = 8'h00; idle(4);
      rd(3'd4);
    end

    // R9: unused addresses and read-only writes
    cur_req = "R9";
    for (int a = 5; a < 8; a++) begin rd(3'(a)); expect_rd(8'h00, "unused addr"); end
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    rd(3'd2); expect_rd(8'h00, "pending untouched by write");
    rd(3'd0); expect_rd(8'h0F, "mode untouched");
    idle(2);
    expect_rd(8'h0F, "rd_data held");

    // R10: edge to level drops the capture
    cur_req = "R10";
    irq_in = 8'h02; idle(2); irq_in = 8'h00; idle(3);
    rd(3'd2); expect_rd(8'h02, "captured before switch");
    wr(3'd0, 8'h00);
    rd(3'd2); expect_rd(8'h00, "dropped after switch");

    // mixed random traffic against the model
    cur_req = "R5";
    for (int c = 0; c < 3000; c++) begin
      irq_in = 8'($urandom);
      case ($urandom % 8)
        0: begin wr_en = 1'b1; addr = 3'd0; wr_data = 8'($urandom); end
        1: begin wr_en = 1'b1; addr = 3'd1; wr_data = 8'($urandom); end
        2, 3: begin rd_en = 1'b1; addr = 3'($urandom); end
        4: begin rd_en = 1'b1; addr = 3'd4; end
        default: ;
      endcase
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule